// File: doc/BRIEF.md
# Pipeline Clock Gating Controller

This block stops the clock of two idle units in a five-stage pipeline (fetch, decode, execute, memory, writeback). The first unit is the floating-point unit in the execute stage. The second is the writeback register stage.

Each cycle the decode stage presents one decoded instruction: a valid bit, a floating-point flag and a writes-a-register flag. The controller registers these flags and moves them down a small shadow pipeline, one stage per clock, so each gating decision follows its instruction. The floating-point clock runs only in cycles when the execute slot holds a valid floating-point instruction. The writeback clock runs only in cycles when the writeback slot holds a valid instruction that writes a result. Bubbles close both clocks.

Each gate is OR-type. A disable level is captured in a latch that is open while the clock is high. It is then ORed with the clock, so a closed gate holds its clock output high. The gate adds one gate delay to the clock path and can take the place of a buffer in the clock tree.

The decode interface has a valid bit and no ready. The controller never applies back-pressure: it takes one instruction slot on every clock edge, and a cycle without a valid instruction counts as a bubble.

From reset until the first valid instruction has been taken, both clocks run freely.

Top module: `pcg_ctrl`

## Requirements
- R1: While a unit's enable output is low, its gated clock stays high for the whole cycle. While the enable is high, the gated clock follows `clk`.
- R2: The floating-point enable is high during a cycle exactly when the execute slot holds a valid instruction with `dec_is_fp`=1. An instruction taken at a clock edge occupies the execute slot for the cycle that follows that edge.
- R3: The writeback enable is high during a cycle exactly when the writeback slot holds a valid instruction with `dec_writes_reg`=1.
- R4: Instruction flags move one stage per clock. An instruction reaches the writeback slot two cycles after it occupies the execute slot.
- R5: A bubble (`dec_valid`=0) closes both clocks when it reaches each slot, whatever values the flag inputs carry.
- R6: During reset, and afterwards until the first valid instruction has been taken, both enables are high and both gated clocks toggle.
- R7: A unit's latched disable changes only while `clk` is high.
- R8: Every rising edge of a gated clock coincides with a rising edge of `clk`. Over a run, the number of rising edges on a gated clock equals the number of cycles in which its enable was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode slot holds a real instruction this cycle |
| dec_is_fp | input | 1 | Decoded instruction uses the floating-point unit |
| dec_writes_reg | input | 1 | Decoded instruction writes a result register |
| fp_clk_en | output | 1 | Floating-point unit clock enabled this cycle |
| wb_clk_en | output | 1 | Writeback stage clock enabled this cycle |
| fp_gclk | output | 1 | Gated clock to the floating-point unit |
| wb_gclk | output | 1 | Gated clock to the writeback stage |

## Verification
The bench targets the two-cycle offset between the execute and writeback decisions. A design that gated writeback from the execute slot would open the writeback clock too early, and only for instructions that write. It drives bubbles whose flag inputs are high. A design that trusted the flags without the valid bit would leak clock edges. It also checks the free-running window before the first valid instruction: a design that gated from reset would starve both units. Finally, it counts gated edges per unit and checks the clock level in each low phase. A gate built as AND-type, or with an unlatched disable, would show extra edges or a low level where a high one is due.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef struct packed {
    logic vld;
    logic fp;
    logic wr;
  } slot_t;

  localparam int unsigned UNIT_FP = 0;
  localparam int unsigned UNIT_WB = 1;
  localparam int unsigned NUM_UNITS = 2;
endpackage

// File: rtl/pcg_shadow_pipe.sv
module pcg_shadow_pipe
  import pcg_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  slot_t                din,
  output slot_t [DEPTH-1:0]    stg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  if (DEPTH > 2) begin : g_follow
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> stg[2] == $past(stg[1])) else $error("slot advance");  // R4
  end
endmodule

// File: rtl/pcg_or_gate.sv
module pcg_or_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_d,
  output logic gclk,
  output logic en
);
  logic dis_q;

  always_latch begin
    if (clk) dis_q = dis_d;
  end

  assign gclk = clk | dis_q;
  assign en   = ~dis_q;

  always @(dis_q) begin
    if (rst_n) AST_DIS_CHANGES_HIGH: assert (clk) else $error("disable moved in low phase");  // R7
  end

  AST_CLOSED_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> gclk) else $error("closed gate low");  // R1
endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int unsigned EX_TO_WB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_valid,
  input  logic dec_is_fp,
  input  logic dec_writes_reg,
  output logic fp_clk_en,
  output logic wb_clk_en,
  output logic fp_gclk,
  output logic wb_gclk
);
  localparam int unsigned DEPTH  = EX_TO_WB + 1;
  localparam int unsigned EX_IDX = 0;
  localparam int unsigned WB_IDX = EX_TO_WB;

  slot_t              din;
  slot_t [DEPTH-1:0]  stg;
  logic               started;
  logic [NUM_UNITS-1:0] unit_dis, unit_gclk, unit_en;

  assign din = '{vld: dec_valid, fp: dec_is_fp, wr: dec_writes_reg};

  pcg_shadow_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din(din), .stg(stg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         started <= 1'b0;
    else if (dec_valid) started <= 1'b1;
  end

  always_comb begin
    unit_dis[UNIT_FP] = started & ~(stg[EX_IDX].vld & stg[EX_IDX].fp);
    unit_dis[UNIT_WB] = started & ~(stg[WB_IDX].vld & stg[WB_IDX].wr);
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_gate
    pcg_or_gate u_gate (
      .clk(clk), .rst_n(rst_n), .dis_d(unit_dis[u]),
      .gclk(unit_gclk[u]), .en(unit_en[u])
    );
  end

  assign fp_gclk   = unit_gclk[UNIT_FP];
  assign wb_gclk   = unit_gclk[UNIT_WB];
  assign fp_clk_en = unit_en[UNIT_FP];
  assign wb_clk_en = unit_en[UNIT_WB];

  AST_OPEN_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> fp_clk_en && wb_clk_en) else $error("gated before start");  // R6
  AST_FP_IDLE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    started && stg[EX_IDX].vld && !stg[EX_IDX].fp |-> !fp_clk_en) else $error("fp open on int");  // R2
  AST_WB_NOWRITE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    started && stg[WB_IDX].vld && !stg[WB_IDX].wr |-> !wb_clk_en) else $error("wb open on no-write");  // R3
  AST_BUBBLE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    started && !stg[WB_IDX].vld |-> !wb_clk_en) else $error("wb open on bubble");  // R5
endmodule

// File: tb/pcg_ctrl_tb.sv
`timescale 1ns/1ps
module pcg_ctrl_tb;
  typedef struct packed { logic v; logic fp; logic wr; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_is_fp = 1'b0, dec_writes_reg = 1'b0;
  logic fp_clk_en, wb_clk_en, fp_gclk, wb_gclk;

  int checks = 0, failures = 0;
  item_t q[$];
  item_t h0 = '0, h1 = '0, h2 = '0;
  bit started = 0, mon_on = 0, count_on = 0;
  logic cur_fp = 1'b1, cur_wb = 1'b1;
  int exp_fp_edges = 0, exp_wb_edges = 0, fp_edges = 0, wb_edges = 0;

  always #2 clk = ~clk;

  pcg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_fp(dec_is_fp),
    .dec_writes_reg(dec_writes_reg), .fp_clk_en(fp_clk_en), .wb_clk_en(wb_clk_en),
    .fp_gclk(fp_gclk), .wb_gclk(wb_gclk)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic fp, input logic wr);
    @(negedge clk);
    dec_valid = v; dec_is_fp = fp; dec_writes_reg = wr;
    q.push_back('{v: v, fp: fp, wr: wr});
    mon_on = 1;
  endtask

  // scoreboard monitor: each cycle take the item just captured, shift model slots
  always @(posedge clk) begin
    #1;
    if (mon_on && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      h2 = h1; h1 = h0; h0 = it;
      if (it.v) started = 1;
      cur_fp = !started || (h0.v && h0.fp);  // R2 R5 R6
      cur_wb = !started || (h2.v && h2.wr);  // R3 R4 R5 R6
      chk("R2", "fp_clk_en", fp_clk_en, cur_fp);
      chk("R3", "wb_clk_en", wb_clk_en, cur_wb);
      exp_fp_edges += int'(cur_fp);
      exp_wb_edges += int'(cur_wb);
      count_on = 1;
    end
  end

  // low phase: closed gate stays high, open gate is low
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      chk("R1", "fp_gclk low-phase", fp_gclk, !cur_fp);
      chk("R1", "wb_gclk low-phase", wb_gclk, !cur_wb);
    end
  end

  always @(posedge fp_gclk) if (count_on) begin
    fp_edges++;
    chk("R8", "clk high at fp edge", clk, 1'b1);
  end
  always @(posedge wb_gclk) if (count_on) begin
    wb_edges++;
    chk("R8", "clk high at wb edge", clk, 1'b1);
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R6", "fp_clk_en in reset", fp_clk_en, 1'b1);
    chk("R6", "wb_clk_en in reset", wb_clk_en, 1'b1);
    @(negedge clk); #1;
    chk("R6", "fp_gclk low in reset", fp_gclk, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // pre-start bubbles with flags set: clocks must stay open (R6)
    drive(0, 1, 1); drive(0, 0, 1);
    // scripted mix
    drive(1, 1, 1);   // fp with result
    drive(1, 0, 1);   // integer with result
    drive(1, 0, 0);   // store
    drive(1, 1, 0);   // fp compare to flags
    drive(0, 1, 1);   // bubble with flags high (R5)
    drive(1, 1, 1); drive(1, 1, 1);  // back-to-back fp
    drive(0, 0, 0); drive(0, 1, 1);
    drive(1, 0, 1);
    for (int i = 0; i < 60; i++)
      drive(logic'((i % 5) != 3), logic'((i % 3) == 0), logic'((i % 4) != 1));
    repeat (4) drive(0, 1, 1);
    @(posedge clk); #2;
    mon_on = 0;
    @(posedge clk); #1;
    count_on = 0;
    chk("R8", "fp edge count match", logic'(fp_edges == exp_fp_edges), 1'b1);
    chk("R8", "wb edge count match", logic'(wb_edges == exp_wb_edges), 1'b1);
    if (fp_edges != exp_fp_edges || wb_edges != exp_wb_edges)
      $display("  edges fp=%0d/%0d wb=%0d/%0d", fp_edges, exp_fp_edges, wb_edges, exp_wb_edges);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule